// File: doc/BRIEF.md
# Display Serial Read Response Decoder

This block sits behind the receive FIFO of a display serial link host and interprets what a panel sends back after a bus turnaround. A transaction starts with a one-cycle `start_i`. The block latches the number of reply words (`word_cnt_i`) and the caller's receive limit (`max_len_i`). It then pops a link status word, a reply header word, and `word_cnt_i - 1` payload words from the FIFO, at most one word per cycle and only while the FIFO presents a valid word.

The status word is classified as acknowledge, escape or unknown. The header's data type, in bits 5:0, selects how the rest of the header is unpacked:
- an acknowledge-with-error report delivers a 16-bit error vector;
- a short read reply delivers one or two bytes taken straight from the header;
- a long read reply (DCS or generic) delivers a 16-bit byte count, and its payload words are unpacked little-endian onto four byte lanes.

The reported size is always clipped to the caller's limit. An unknown data type stops the transaction at once and raises a protocol-error flag. `done_o` pulses when the transaction ends.

Lane reception, ECC and checksum checking happen upstream of this block.

Top module: `dsi_rd_resp_dec`

## Requirements
- R1: The first word popped after `start_i` is the status word. It sets `status_o` to 1 if the word equals 0x00000084, to 2 if it equals 0x00000087, and to 3 for any other value. `status_o` is 0 after reset and after each accepted `start_i`.
- R2: A header whose bits 5:0 equal 0x02 sets `err_vec_o` to header bits 23:8. Bit 0 is SoT error, bits 8 and 9 are single- and multi-bit ECC, bit 10 is checksum, and bit 15 is protocol violation. `size_o` stays 0 and no byte lane is enabled for this reply.
- R3: A header type of 0x21 is a one-byte reply. Header bits 15:8 appear on `data_o[7:0]` with `data_en_o` = 0001, and `size_o` = min(1, max). When max is 0, no lane is enabled.
- R4: A header type of 0x22 is a two-byte reply. Byte 0 comes from header bits 15:8 and appears on lane 0 (`data_o[7:0]`). Byte 1 comes from bits 23:16 and appears on lane 1 (`data_o[15:8]`). `size_o` = min(2, max), and lane k is enabled only when k < max.
- R5: A header type of 0x1A or 0x1C is a long reply. Its byte count is header bits 23:8, with bits 15:8 as the low byte. `size_o` = min(count, max), and the header itself enables no lane.
- R6: For a long reply, payload word j (0-based) is passed to `data_o` unchanged, so byte k sits in bits 8k+7:8k. Lane k is enabled exactly when 4j+k < max. The enabled lanes always form a contiguous run starting at lane 0. Payload words of any other reply type are popped but enable no lane.
- R7: Any other header type sets `proto_err_o`, ends the transaction with `done_o` one cycle after the header is popped, and pops no further word. `size_o` stays 0 and no lane is enabled.
- R8: `fifo_pop_o` is high only while a transaction is running and `fifo_valid_i` is high. The block pops 1 + `word_cnt_i` words in total, and `done_o` is a single-cycle pulse in the cycle after the last pop. With `word_cnt_i` = 0, only the status word is popped.
- R9: After reset, `fifo_pop_o`, `done_o`, `data_en_o`, `size_o`, `err_vec_o`, `status_o` and `proto_err_o` are all 0.
- R10: A `start_i` that arrives while a transaction is running is ignored and does not change that transaction's word count, limit or results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin decoding one reply (taken when idle) |
| word_cnt_i | input | CNT_W | Reply words in the FIFO: header plus payload |
| max_len_i | input | LEN_W | Caller's maximum receive length in bytes |
| fifo_data_i | input | 32 | FIFO head word |
| fifo_valid_i | input | 1 | FIFO head word is valid |
| fifo_pop_o | output | 1 | Consume the FIFO head word this cycle |
| data_o | output | 32 | Received bytes, four lanes, lane k in bits 8k+7:8k |
| data_en_o | output | 4 | Lane enables for `data_o`, one-cycle |
| size_o | output | LEN_W | Decoded byte count clipped to the limit |
| err_vec_o | output | 16 | Error flags from an acknowledge-with-error reply |
| status_o | output | 2 | 0 none, 1 acknowledge, 2 escape, 3 unknown |
| proto_err_o | output | 1 | Unrecognised reply data type |
| done_o | output | 1 | One-cycle pulse when the transaction ends |

## Verification
The bench keeps the FIFO full and counts clock edges from the edge that takes `start_i`. The status word is popped at edge 1 and `status_o` is valid just after it. The header is popped at edge 2, and `size_o`, `err_vec_o`, `proto_err_o` and the header's lanes are valid just after that edge. Payload word j is popped at edge 3 + j, and `done_o` appears after edge 1 + `word_cnt_i`, or after edge 2 when the data type is unknown. When valid is held low for n extra edges, every one of these results moves later by exactly n edges. All sampling happens on the falling edge, and each run checks the exact index of the `done_o` edge as well as the FIFO read pointer at the points where no pop may occur.

// File: rtl/dsi_rsp_pkg.sv
package dsi_rsp_pkg;
  localparam logic [5:0]  DT_ACK_ERR  = 6'h02;
  localparam logic [5:0]  DT_SHORT1   = 6'h21;
  localparam logic [5:0]  DT_SHORT2   = 6'h22;
  localparam logic [5:0]  DT_LONG_GEN = 6'h1A;
  localparam logic [5:0]  DT_LONG_DCS = 6'h1C;
  localparam logic [31:0] STAT_ACK    = 32'h0000_0084;
  localparam logic [31:0] STAT_ESC    = 32'h0000_0087;

  typedef enum logic [2:0] {K_ACKERR, K_SHORT1, K_SHORT2, K_LONG, K_BAD} rsp_kind_e;
  typedef enum logic [1:0] {ST_NONE = 2'd0, ST_ACK = 2'd1, ST_ESC = 2'd2, ST_UNK = 2'd3} link_stat_e;
  typedef enum logic [1:0] {S_IDLE, S_STAT, S_HDR, S_PAY} seq_state_e;

  function automatic link_stat_e classify_status(logic [31:0] w);
    if (w == STAT_ACK)      return ST_ACK;
    else if (w == STAT_ESC) return ST_ESC;
    else                    return ST_UNK;
  endfunction
endpackage

// File: rtl/rsp_hdr_decode.sv
module rsp_hdr_decode
  import dsi_rsp_pkg::*;
(
  input  logic [31:0] word_i,
  output rsp_kind_e   kind_o,
  output logic [15:0] count_o,
  output logic [15:0] err_o,
  output logic [15:0] short_o,
  output logic [3:0]  cap_o
);
  always_comb begin
    kind_o  = K_BAD;
    count_o = '0;
    err_o   = '0;
    short_o = word_i[23:8];
    cap_o   = 4'b0000;
    unique case (word_i[5:0])
      DT_ACK_ERR: begin
        kind_o = K_ACKERR;
        err_o  = word_i[23:8];
      end
      DT_SHORT1: begin
        kind_o  = K_SHORT1;
        count_o = 16'd1;
        cap_o   = 4'b0001;
      end
      DT_SHORT2: begin
        kind_o  = K_SHORT2;
        count_o = 16'd2;
        cap_o   = 4'b0011;
      end
      DT_LONG_GEN, DT_LONG_DCS: begin
        kind_o  = K_LONG;
        count_o = {word_i[23:16], word_i[15:8]};
      end
      default: kind_o = K_BAD;
    endcase
  end
endmodule

// File: rtl/rsp_lane_mask.sv
module rsp_lane_mask #(
  parameter int IDX_W = 17,
  parameter int LANES = 4
) (
  input  logic [IDX_W-1:0] base_i,
  input  logic [IDX_W-1:0] limit_i,
  output logic [LANES-1:0] en_o
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign en_o[k] = (base_i + IDX_W'(k)) < limit_i;
  end
endmodule

// File: rtl/dsi_rd_resp_dec.sv
module dsi_rd_resp_dec
  import dsi_rsp_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] word_cnt_i,
  input  logic [LEN_W-1:0] max_len_i,
  input  logic [31:0]      fifo_data_i,
  input  logic             fifo_valid_i,
  output logic             fifo_pop_o,
  output logic [31:0]      data_o,
  output logic [3:0]       data_en_o,
  output logic [LEN_W-1:0] size_o,
  output logic [15:0]      err_vec_o,
  output logic [1:0]       status_o,
  output logic             proto_err_o,
  output logic             done_o
);
  localparam int LANES = 4;
  localparam int BASE_W = (LEN_W > CNT_W + 2) ? LEN_W : CNT_W + 2;
  localparam int IDX_W = ((BASE_W > 16) ? BASE_W : 16) + 1;

  seq_state_e       state_q;
  logic [CNT_W-1:0] rem_q;
  logic [LEN_W-1:0] max_q;
  logic [IDX_W-1:0] pay_idx_q;
  logic             long_q;

  rsp_kind_e        hdr_kind;
  logic [15:0]      hdr_count, hdr_err, hdr_short;
  logic [3:0]       hdr_cap, lane_en;
  logic [IDX_W-1:0] lane_base, max_x, cnt_x, clip_x;

  rsp_hdr_decode u_hdr (
    .word_i (fifo_data_i),
    .kind_o (hdr_kind),
    .count_o(hdr_count),
    .err_o  (hdr_err),
    .short_o(hdr_short),
    .cap_o  (hdr_cap)
  );

  assign lane_base = (state_q == S_HDR) ? '0 : pay_idx_q;
  assign max_x     = IDX_W'(max_q);
  assign cnt_x     = IDX_W'(hdr_count);
  assign clip_x    = (cnt_x < max_x) ? cnt_x : max_x;

  rsp_lane_mask #(.IDX_W(IDX_W), .LANES(LANES)) u_mask (
    .base_i (lane_base),
    .limit_i(max_x),
    .en_o   (lane_en)
  );

  assign fifo_pop_o = fifo_valid_i && (state_q != S_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      rem_q       <= '0;
      max_q       <= '0;
      pay_idx_q   <= '0;
      long_q      <= 1'b0;
      data_o      <= '0;
      data_en_o   <= '0;
      size_o      <= '0;
      err_vec_o   <= '0;
      status_o    <= ST_NONE;
      proto_err_o <= 1'b0;
      done_o      <= 1'b0;
    end else begin
      data_en_o <= '0;
      done_o    <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          rem_q       <= word_cnt_i;
          max_q       <= max_len_i;
          size_o      <= '0;
          err_vec_o   <= '0;
          status_o    <= ST_NONE;
          proto_err_o <= 1'b0;
          long_q      <= 1'b0;
          state_q     <= S_STAT;
        end
        S_STAT: if (fifo_pop_o) begin
          status_o <= classify_status(fifo_data_i);
          if (rem_q == '0) begin
            done_o  <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            state_q <= S_HDR;
          end
        end
        S_HDR: if (fifo_pop_o) begin
          if (hdr_kind == K_BAD) begin
            proto_err_o <= 1'b1;
            done_o      <= 1'b1;
            state_q     <= S_IDLE;
          end else begin
            size_o    <= LEN_W'(clip_x);
            err_vec_o <= hdr_err;
            data_o    <= {16'h0000, hdr_short};
            data_en_o <= lane_en & hdr_cap;
            long_q    <= (hdr_kind == K_LONG);
            pay_idx_q <= '0;
            rem_q     <= rem_q - 1'b1;
            if (rem_q == CNT_W'(1)) begin
              done_o  <= 1'b1;
              state_q <= S_IDLE;
            end else begin
              state_q <= S_PAY;
            end
          end
        end
        S_PAY: if (fifo_pop_o) begin
          data_o    <= fifo_data_i;
          data_en_o <= long_q ? lane_en : 4'b0000;
          pay_idx_q <= pay_idx_q + IDX_W'(LANES);
          rem_q     <= rem_q - 1'b1;
          if (rem_q == CNT_W'(1)) begin
            done_o  <= 1'b1;
            state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // lanes are always filled from lane 0 upward
  assert_lanes_contig_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((data_en_o & (data_en_o + 4'd1)) == 4'd0));

  assert_size_clip_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size_o <= max_q));

  assert_proto_silent_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |-> (size_o == '0 && data_en_o == 4'd0));

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_err_no_bytes_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_vec_o != 16'h0) |-> (size_o == '0 && data_en_o == 4'd0));
endmodule

// File: tb/sim_dsi_rd_resp_dec.sv
module sim_dsi_rd_resp_dec;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, start;
  logic [4:0]  wc;
  logic [15:0] maxl;
  logic [31:0] fdata, dout;
  logic        fvalid, pop, perr, done;
  logic [3:0]  den;
  logic [15:0] size, errv;
  logic [1:0]  stat;

  dsi_rd_resp_dec u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .word_cnt_i(wc), .max_len_i(maxl),
    .fifo_data_i(fdata), .fifo_valid_i(fvalid), .fifo_pop_o(pop),
    .data_o(dout), .data_en_o(den), .size_o(size), .err_vec_o(errv),
    .status_o(stat), .proto_err_o(perr), .done_o(done)
  );

  logic [31:0] mem [0:63];
  int wr = 0, rd = 0, cyc_no = 0, stall_until = 0;
  logic flush = 1'b0;
  int errors = 0, checks = 0;
  logic [7:0] gb [0:63];
  int gn, got_cyc, rd0, rd_mid;

  assign fvalid = (rd < wr) && (cyc_no >= stall_until);
  assign fdata  = mem[rd[5:0]];

  always @(posedge clk) begin
    cyc_no <= cyc_no + 1;
    if (flush) rd <= wr;
    else if (pop) rd <= rd + 1;
  end

  always @(posedge clk) if (cyc_no > 50000) begin
    errors++; checks++;
    $display("FAIL R8 watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] w);
    mem[wr[5:0]] = w;
    wr = wr + 1;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  task automatic run(input int n_wc, input int n_max, input int n_stall, input bit poke);
    @(negedge clk);
    start = 1'b1; wc = n_wc[4:0]; maxl = n_max[15:0];
    stall_until = cyc_no + n_stall; gn = 0; got_cyc = 0; rd0 = rd; rd_mid = rd;
    @(negedge clk);
    start = 1'b0;
    for (int c = 1; c <= 100; c++) begin
      if (poke && c == 1) begin start = 1'b1; wc = 5'd7; maxl = 16'd0; end
      @(negedge clk);
      start = 1'b0;
      if (c == 2) rd_mid = rd;
      for (int k = 0; k < 4; k++) if (den[k]) begin gb[gn[5:0]] = dout[8*k +: 8]; gn++; end
      if (done) begin got_cyc = c; break; end
    end
  endtask

  task automatic chk_bytes(input string req, input logic [7:0] e [0:7], input int n);
    chk({req, " byte count"}, gn, n);
    for (int i = 0; i < n && i < gn; i++) chk({req, " byte"}, gb[i], e[i]);
  endtask

  task automatic t_reset();
    chk("R9 pop", pop, 0);
    chk("R9 done", done, 0);
    chk("R9 size", size, 0);
    chk("R9 status", stat, 0);
    chk("R9 proto", perr, 0);
    chk("R9 err", errv, 0);
    chk("R9 lanes", den, 0);
  endtask

  task automatic t_ack_err();
    push(32'h0000_0084); push(32'h0003_0102);
    run(1, 8, 0, 0);
    chk("R1 status ack", stat, 1);
    chk("R2 err vec", errv, 16'h0301);
    chk("R2 size", size, 0);
    chk("R2 no bytes", gn, 0);
    chk("R8 done cycle", got_cyc, 2);
    chk("R8 all popped", rd, wr);
  endtask

  task automatic t_short1();
    logic [7:0] e [0:7];
    e = '{8'hAB, 0, 0, 0, 0, 0, 0, 0};
    push(32'h0000_0087); push(32'h0000_AB21);
    run(1, 4, 0, 0);
    chk("R1 status esc", stat, 2);
    chk("R3 size", size, 1);
    chk_bytes("R3", e, 1);
    push(32'h0000_0084); push(32'h0000_AB21);
    run(1, 0, 0, 0);
    chk("R3 max0 size", size, 0);
    chk("R3 max0 bytes", gn, 0);
  endtask

  task automatic t_short2();
    logic [7:0] e [0:7];
    e = '{8'hEF, 8'hCD, 0, 0, 0, 0, 0, 0};
    push(32'h0000_0084); push(32'h00CD_EF22);
    run(1, 1, 0, 0);
    chk("R4 clip size", size, 1);
    chk_bytes("R4 clip", e, 1);
    push(32'h0000_0084); push(32'h00CD_EF22);
    run(1, 8, 0, 0);
    chk("R4 size", size, 2);
    chk_bytes("R4", e, 2);
  endtask

  task automatic t_long();
    logic [7:0] e [0:7];
    e = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 8'h88};
    push(32'h1234_5678); push(32'h0000_061C); push(32'h4433_2211); push(32'h8877_6655);
    run(3, 16, 0, 0);
    chk("R1 status unknown", stat, 3);
    chk("R5 size", size, 6);
    chk_bytes("R6 full", e, 8);
    chk("R8 done cycle", got_cyc, 4);
    push(32'h0000_0084); push(32'h0000_061C); push(32'h4433_2211); push(32'h8877_6655);
    run(3, 5, 0, 0);
    chk("R5 clip size", size, 5);
    chk_bytes("R6 clip", e, 5);
    push(32'h0000_0084); push(32'h0001_021A);
    run(1, 300, 0, 0);
    chk("R5 generic count", size, 258);
  endtask

  task automatic t_proto();
    push(32'h0000_0084); push(32'h00AA_BB05); push(32'h1111_1111); push(32'h2222_2222);
    run(3, 16, 0, 0);
    chk("R7 proto", perr, 1);
    chk("R7 done cycle", got_cyc, 2);
    chk("R7 size", size, 0);
    chk("R7 bytes", gn, 0);
    chk("R7 words left", wr - rd, 2);
    do_flush();
  endtask

  task automatic t_stall_busy_start();
    logic [7:0] e [0:7];
    e = '{8'hAA, 8'hBB, 0, 0, 0, 0, 0, 0};
    push(32'h0000_0084); push(32'h0000_031C); push(32'hDDCC_BBAA);
    run(2, 2, 3, 1);
    chk("R8 no pop while invalid", rd_mid, rd0);
    chk("R8 stall done cycle", got_cyc, 5);
    chk("R10 size kept", size, 2);
    chk_bytes("R10 bytes kept", e, 2);
    chk("R10 all popped", rd, wr);
    @(negedge clk);
    chk("R10 idle after", pop, 0);
  endtask

  task automatic t_zero_count();
    push(32'h0000_0087);
    run(0, 4, 0, 0);
    chk("R8 zero count done", got_cyc, 1);
    chk("R8 zero count status", stat, 2);
    chk("R8 zero count popped", rd, wr);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; wc = '0; maxl = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_ack_err();
    t_short1();
    t_short2();
    t_long();
    t_proto();
    t_stall_busy_start();
    t_zero_count();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule